// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block sits on the receive byte path of an Ethernet controller and looks for a wake-up pattern inside each frame. The pattern has two parts. First comes a run of at least six bytes of 0xFF. Then come sixteen back-to-back copies of the station's own 6-byte address. The pattern can begin at any byte position in the frame. Filler bytes are allowed between the 0xFF run and the first address copy.

Finding the pattern does not raise a wake by itself. The block keeps the match until the frame's last byte arrives. At that point it qualifies the match using four inputs, all sampled on the end-of-frame beat:

- the upstream destination-address filter result,
- the upstream CRC-good result,
- the magic-wake enable,
- the global wake enable.

When all of them are set, the block emits one single-cycle wake pulse.

Bytes arrive one per cycle while `rx_valid` is high. `rx_sof` marks the first byte of a frame and `rx_eof` marks the last. Both are meaningful only together with `rx_valid`. `rx_abort` discards the frame in progress. Address filtering and CRC checking are done upstream.

Top module: `wol_magic_detect`

## Requirements
- R1: After synchronous reset, `wake_pulse` is 0 and no match is held.
- R2: A frame that contains the full pattern, has all four qualifiers high on its end-of-frame beat and is not aborted produces `wake_pulse` high exactly in the cycle after that beat, for one cycle only.
- R3: The 0xFF run may start at any byte offset in the frame, including offset 0.
- R4: A run of more than six consecutive 0xFF bytes is accepted as the synchronisation run.
- R5: Once six or more 0xFF bytes have been seen, any number of bytes that are neither 0xFF nor address byte 0 may follow before the first address copy.
- R6: A byte that breaks an address copy sends the matcher back to counting 0xFF bytes. If that byte is itself 0xFF, it counts as the first byte of a new run.
- R7: Fewer than six 0xFF bytes, or fewer than sixteen complete copies, produce no pulse.
- R8: If `da_match` is low on the end-of-frame beat, no pulse is produced.
- R9: If `crc_ok` is low on the end-of-frame beat, no pulse is produced.
- R10: No pulse is produced unless both `magic_en` and `wake_en` are high on the end-of-frame beat.
- R11: All match state clears on a beat that carries `rx_sof`, and on any cycle with `rx_abort`. An abort on the end-of-frame beat suppresses the pulse.
- R12: Address bytes are expected in wire order. Byte 0 of each copy is `station_addr[47:40]` and byte 5 is `station_addr[7:0]`. Byte 0 must not be 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A byte is present on `rx_data` this cycle |
| rx_sof | input | 1 | This byte is the first byte of a frame |
| rx_eof | input | 1 | This byte is the last byte of a frame |
| rx_abort | input | 1 | Discard the frame in progress |
| rx_data | input | 8 | Received byte |
| station_addr | input | 48 | Station address, wire byte 0 in the top bits |
| da_match | input | 1 | Destination filter hit, sampled at end of frame |
| crc_ok | input | 1 | Frame check good, sampled at end of frame |
| magic_en | input | 1 | Magic-wake enable |
| wake_en | input | 1 | Global wake enable |
| wake_pulse | output | 1 | One-cycle wake event |

## Verification
The bench uses the default parameters: a six-byte synchronisation run, sixteen copies and a six-byte address. A full pattern is then about a hundred bytes, so whole frames stay short. This makes it possible to sweep several things frame by frame:

- the pattern offset across two dozen positions,
- the 0xFF run length on both sides of six,
- the copy count on both sides of sixteen,
- the filler length,
- all sixteen combinations of the four qualifiers.

The expected result of each frame is computed from the counts alone. Directed frames cover re-synchronisation after a broken copy, a second start-of-frame, aborts, and byte order.

// File: rtl/wol_magic_pkg.sv
package wol_magic_pkg;

    localparam logic [7:0] SYNC_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        PH_HUNT  = 2'd0,
        PH_COPY  = 2'd1,
        PH_FOUND = 2'd2
    } wol_phase_e;

    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eof;
        logic       abort;
        logic [7:0] data;
    } wol_beat_t;

    function automatic logic is_sync(input logic [7:0] b);
        return b == SYNC_BYTE;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wol_addr_slicer.sv
module wol_addr_slicer
    import wol_magic_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int BI_W = idx_width(ADDR_BYTES),
    localparam int SLOTS = 1 << BI_W
) (
    input  logic [8*ADDR_BYTES-1:0] addr,
    input  logic [BI_W-1:0]         idx,
    output logic [7:0]              sel_byte,
    output logic [7:0]              first_byte
);
    logic [7:0] slot [SLOTS];

    // Wire order: slot 0 holds the most significant byte.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < ADDR_BYTES) begin : g_real
            assign slot[g] = addr[8*(ADDR_BYTES-g)-1 -: 8];
        end else begin : g_pad
            assign slot[g] = 8'h00;
        end
    end

    assign sel_byte   = slot[idx];
    assign first_byte = slot[0];
endmodule

// File: rtl/wol_pattern_matcher.sv
module wol_pattern_matcher
    import wol_magic_pkg::*;
#(
    parameter int SYNC_LEN   = 6,
    parameter int COPY_COUNT = 16,
    parameter int ADDR_BYTES = 6,
    localparam int FF_W = idx_width(SYNC_LEN + 1),
    localparam int CP_W = idx_width(COPY_COUNT),
    localparam int BI_W = idx_width(ADDR_BYTES)
) (
    input  logic            clk,
    input  logic            rst,
    input  wol_beat_t       beat,
    input  logic [7:0]      cur_addr_byte,
    input  logic [7:0]      first_addr_byte,
    output logic [BI_W-1:0] byte_idx,
    output logic            found_now
);
    localparam logic [FF_W-1:0] FF_FULL   = FF_W'(SYNC_LEN);
    localparam logic [CP_W-1:0] CP_LAST   = CP_W'(COPY_COUNT - 1);
    localparam logic [BI_W-1:0] BI_LAST   = BI_W'(ADDR_BYTES - 1);

    wol_phase_e      ph_q, ph_b, ph_n;
    logic [FF_W-1:0] ff_q, ff_b, ff_n;
    logic [CP_W-1:0] cp_q, cp_b, cp_n;
    logic [BI_W-1:0] bi_q, bi_b, bi_n;
    logic            fresh;

    assign fresh = beat.valid && beat.sof;

    always_comb begin
        ph_b = fresh ? PH_HUNT : ph_q;
        ff_b = fresh ? '0 : ff_q;
        cp_b = fresh ? '0 : cp_q;
        bi_b = fresh ? '0 : bi_q;
        ph_n = ph_b;
        ff_n = ff_b;
        cp_n = cp_b;
        bi_n = bi_b;
        if (beat.abort) begin
            ph_n = PH_HUNT;
            ff_n = '0;
            cp_n = '0;
            bi_n = '0;
        end else if (beat.valid) begin
            unique case (ph_b)
                PH_HUNT: begin
                    if (is_sync(beat.data)) begin
                        ff_n = (ff_b == FF_FULL) ? ff_b : ff_b + FF_W'(1);
                    end else if (ff_b == FF_FULL) begin
                        // Armed: the first address byte opens the copies,
                        // any other byte is skipped as filler.
                        if (beat.data == first_addr_byte) begin
                            ph_n = PH_COPY;
                            bi_n = BI_W'(1);
                            cp_n = '0;
                        end
                    end else begin
                        ff_n = '0;
                    end
                end
                PH_COPY: begin
                    if (beat.data == cur_addr_byte) begin
                        if (bi_b == BI_LAST) begin
                            bi_n = '0;
                            if (cp_b == CP_LAST) ph_n = PH_FOUND;
                            else                 cp_n = cp_b + CP_W'(1);
                        end else begin
                            bi_n = bi_b + BI_W'(1);
                        end
                    end else begin
                        ph_n = PH_HUNT;
                        ff_n = is_sync(beat.data) ? FF_W'(1) : '0;
                        cp_n = '0;
                        bi_n = '0;
                    end
                end
                default: ph_n = PH_FOUND;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_HUNT;
            ff_q <= '0;
            cp_q <= '0;
            bi_q <= '0;
        end else begin
            ph_q <= ph_n;
            ff_q <= ff_n;
            cp_q <= cp_n;
            bi_q <= bi_n;
        end
    end

    assign byte_idx  = bi_q;
    assign found_now = (ph_n == PH_FOUND);

    assert_ffcnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        ff_q <= FF_FULL);
    assert_copy_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cp_q <= CP_LAST && bi_q <= BI_LAST);
    assert_abort_clears_R11: assert property (@(posedge clk) disable iff (rst)
        beat.abort |=> (ph_q == PH_HUNT && ff_q == '0));
    assert_found_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_FOUND && !beat.abort && !fresh) |=> ph_q == PH_FOUND);
    assert_copy_needs_sync_R7: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_HUNT && beat.valid && !fresh && !beat.abort && ff_q != FF_FULL)
            |=> ph_q != PH_COPY);
endmodule

// File: rtl/wol_wake_qualifier.sv
module wol_wake_qualifier (
    input  logic clk,
    input  logic rst,
    input  logic frame_end,
    input  logic found_now,
    input  logic da_match,
    input  logic crc_ok,
    input  logic magic_en,
    input  logic wake_en,
    output logic wake_pulse
);
    logic grant;

    assign grant = found_now && da_match && crc_ok && magic_en && wake_en;

    always_ff @(posedge clk) begin
        if (rst) wake_pulse <= 1'b0;
        else     wake_pulse <= frame_end && grant;
    end

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);
    assert_pulse_after_end_R2: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(frame_end));
    assert_dest_gate_R8: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(da_match));
    assert_crc_gate_R9: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(crc_ok));
    assert_enable_gate_R10: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(magic_en && wake_en));
endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect
    import wol_magic_pkg::*;
#(
    parameter int SYNC_LEN   = 6,
    parameter int COPY_COUNT = 16,
    parameter int ADDR_BYTES = 6,
    localparam int BI_W = idx_width(ADDR_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic                    rx_abort,
    input  logic [7:0]              rx_data,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic                    da_match,
    input  logic                    crc_ok,
    input  logic                    magic_en,
    input  logic                    wake_en,
    output logic                    wake_pulse
);
    wol_beat_t       beat;
    logic [BI_W-1:0] byte_idx;
    logic [7:0]      cur_byte, first_byte;
    logic            found_now;

    assign beat = '{valid: rx_valid, sof: rx_sof, eof: rx_eof,
                    abort: rx_abort, data: rx_data};

    wol_addr_slicer #(.ADDR_BYTES(ADDR_BYTES)) u_slicer (
        .addr       (station_addr),
        .idx        (byte_idx),
        .sel_byte   (cur_byte),
        .first_byte (first_byte)
    );

    wol_pattern_matcher #(
        .SYNC_LEN   (SYNC_LEN),
        .COPY_COUNT (COPY_COUNT),
        .ADDR_BYTES (ADDR_BYTES)
    ) u_matcher (
        .clk             (clk),
        .rst             (rst),
        .beat            (beat),
        .cur_addr_byte   (cur_byte),
        .first_addr_byte (first_byte),
        .byte_idx        (byte_idx),
        .found_now       (found_now)
    );

    wol_wake_qualifier u_qual (
        .clk        (clk),
        .rst        (rst),
        .frame_end  (rx_valid && rx_eof && !rx_abort),
        .found_now  (found_now),
        .da_match   (da_match),
        .crc_ok     (crc_ok),
        .magic_en   (magic_en),
        .wake_en    (wake_en),
        .wake_pulse (wake_pulse)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !wake_pulse);
endmodule

// File: tb/wol_magic_detect_tb.sv
module wol_magic_detect_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_abort = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [47:0] station_addr = 48'h02_1A_3C_4D_5E_6F;
    logic        da_match = 1'b1, crc_ok = 1'b1, magic_en = 1'b1, wake_en = 1'b1;
    logic        wake_pulse;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [7:0] fb [0:255];

    always #2 clk = ~clk;

    wol_magic_detect u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_abort(rx_abort), .rx_data(rx_data),
        .station_addr(station_addr), .da_match(da_match), .crc_ok(crc_ok),
        .magic_en(magic_en), .wake_en(wake_en), .wake_pulse(wake_pulse)
    );

    task automatic chk(input bit got, input bit exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: wake_pulse=%0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic fill(input int len);
        for (int i = 0; i < len; i++) fb[i] = 8'h55;
    endtask

    task automatic put_ff(inout int pos, input int n);
        for (int i = 0; i < n; i++) begin fb[pos] = 8'hFF; pos++; end
    endtask

    // Wire order: byte 0 is station_addr[47:40]; rev sends low byte first.
    task automatic put_copies(inout int pos, input int n, input bit rev);
        for (int c = 0; c < n; c++)
            for (int b = 0; b < 6; b++) begin
                int k = rev ? (5 - b) : b;
                fb[pos] = station_addr[8*(6-k)-1 -: 8];
                pos++;
            end
    endtask

    task automatic run_frame(input int len, input int abort_idx, input int sof_idx,
                             input string tag, input bit exp);
        bit got;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = fb[i];
            rx_sof   = (i == 0) || (i == sof_idx);
            rx_eof   = (i == len - 1);
            rx_abort = (i == abort_idx);
        end
        @(negedge clk);
        got = wake_pulse;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_abort = 1'b0;
        chk(got, exp, tag);
        @(negedge clk);
        chk(wake_pulse, 1'b0, "R2 width");
        @(negedge clk);
    endtask

    task automatic std_frame(input int off, input int nff, input int nmisc,
                             input int ncp, input bit rev, output int len);
        int p = off;
        fill(off + nff + nmisc + 6*ncp + 4);
        put_ff(p, nff);
        p += nmisc;
        put_copies(p, ncp, rev);
        len = p + 4;
    endtask

    initial begin
        int len;
        int p;
        repeat (3) @(negedge clk);
        chk(wake_pulse, 1'b0, "R1 in reset");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(wake_pulse, 1'b0, "R1 after reset");

        // R3: pattern at many offsets
        for (int off = 0; off < 24; off++) begin
            std_frame(off, 6, 0, 16, 1'b0, len);
            run_frame(len, -1, -1, "R3 offset", 1'b1);
        end

        // R4 / R7: run length sweep
        for (int n = 3; n <= 10; n++) begin
            std_frame(5, n, 0, 16, 1'b0, len);
            run_frame(len, -1, -1, n >= 6 ? "R4 long run" : "R7 short run", n >= 6);
        end

        // R7: copy count sweep
        for (int c = 13; c <= 17; c++) begin
            std_frame(7, 6, 0, c, 1'b0, len);
            run_frame(len, -1, -1, "R7 copy count", c >= 16);
        end

        // R5: filler between run and copies
        for (int m = 0; m <= 5; m++) begin
            std_frame(3, 6, m, 16, 1'b0, len);
            run_frame(len, -1, -1, "R5 filler", 1'b1);
        end

        // R6: broken copy, breaking 0xFF starts a new run
        for (int extra = 4; extra <= 5; extra++) begin
            fill(200);
            p = 2;
            put_ff(p, 6);
            put_copies(p, 2, 1'b0);
            fb[p] = 8'h02; fb[p+1] = 8'h1A; p += 2;
            put_ff(p, 1 + extra);
            put_copies(p, 16, 1'b0);
            run_frame(p + 3, -1, -1, "R6 resync", extra == 5);
        end

        // R8 / R9 / R10: qualifier sweep
        for (int q = 0; q < 16; q++) begin
            std_frame(4, 6, 0, 16, 1'b0, len);
            da_match = q[0]; crc_ok = q[1]; magic_en = q[2]; wake_en = q[3];
            run_frame(len, -1, -1, !q[0] ? "R8 dest" : (!q[1] ? "R9 crc" : "R10 enables"),
                      q == 15);
        end
        da_match = 1'b1; crc_ok = 1'b1; magic_en = 1'b1; wake_en = 1'b1;

        // R11: second start-of-frame, mid abort, abort on last beat
        std_frame(2, 6, 0, 16, 1'b0, len);
        run_frame(len, -1, len - 2, "R11 sof clears", 1'b0);
        std_frame(2, 6, 0, 16, 1'b0, len);
        run_frame(len, len - 3, -1, "R11 abort clears", 1'b0);
        std_frame(2, 6, 0, 16, 1'b0, len);
        run_frame(len, len - 1, -1, "R11 abort at end", 1'b0);
        std_frame(2, 6, 0, 16, 1'b0, len);
        run_frame(len, -1, -1, "R11 recovers", 1'b1);

        // R12: reversed byte order must not match
        std_frame(2, 6, 0, 16, 1'b1, len);
        run_frame(len, -1, -1, "R12 byte order", 1'b0);
        station_addr = 48'h0C_11_22_33_44_55;
        std_frame(9, 6, 0, 16, 1'b0, len);
        run_frame(len, -1, -1, "R12 other address", 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule